// File: doc/BRIEF.md
# Display-List Coprocessor Fetch Engine

This block walks a list of two-word instructions held in shared memory and uses them to program machine registers. It owns a read port on the shared memory, and the memory arbiter lets it read only in odd-numbered slots. Each instruction is read as a pair of 16-bit words at consecutive addresses, and the engine acts only once both words are in.

There are two instructions. A register-load instruction drives a one-cycle write strobe onto a register bus, carrying an 8-bit register number and 16 bits of data. A beam-hold instruction stalls the list until an external beam-position count reaches a target. It then spends one more read slot to wake up, and only after that does it fetch the next instruction.

Software, or another block, starts a list or moves it elsewhere with a one-cycle restart strobe and a start address. After reset the engine stays quiet until the first restart.

Top module: `dlist_engine`

## Requirements
- R1: After reset, and until the first restart strobe, `memRd` and `regWr` stay low.
- R2: `memRd` is asserted only in cycles where `slotOdd` is high.
- R3: An instruction is fetched as two reads, first at the fetch pointer P and then at P+2. The next instruction starts at P+4.
- R4: Bit 0 of the first word is 0 for a register load. `regAddr` equals bits 8..1 of the first word and `regData` equals the second word. `regWr` is high for exactly one cycle, the cycle right after the second read.
- R5: Back-to-back register loads start every 4 slots. Their reads fall in cycles F, F+2, F+4, F+6 and so on, and their writes fall in cycles F+3, F+7 and so on.
- R6: Bit 0 of the first word is 1 for a beam hold, and bits 15..1 of the second word are the target. The wake-up read happens in the first odd slot, no earlier than 4 cycles after the first fetch, in which `beamPos` >= target. It reads the next instruction's address and writes no register. The next fetch comes 2 cycles after the wake-up read.
- R7: A beam hold whose target is already met still takes 6 slots, so the next instruction's first read comes 6 cycles after the hold's first read.
- R8: A restart strobe loads the pointer from `startAddr` with bit 0 cleared and abandons any partial fetch or hold. In the strobe cycle neither `memRd` nor `regWr` is asserted. The first read falls in the first odd slot after the strobe.
- R9: The fetch pointer wraps modulo 2^ADDR_W.
- R10: Bits 15..9 of a register-load first word have no effect on the register address, the data or the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one memory slot |
| rst_n | input | 1 | Active-low asynchronous reset |
| slotOdd | input | 1 | High during odd memory slots, the only slots the engine may read in |
| restart | input | 1 | One-cycle strobe that reloads the pointer and restarts the list |
| startAddr | input | ADDR_W | Byte address of the first instruction for a restart |
| memRd | output | 1 | Memory read request for this slot |
| memAddr | output | ADDR_W | Byte address of the read |
| memRdData | input | 16 | Word returned for the read in the same slot |
| beamPos | input | 15 | Current beam position |
| regWr | output | 1 | One-cycle register write strobe |
| regAddr | output | 8 | Register number for the write |
| regData | output | 16 | Data for the write |

## Verification
The hardest cases to bring about involve the wake-up slot of a beam hold. It depends on three things together: the phase of the odd slots, the earliest cycle at which the hold may resume, and the cycle in which `beamPos` crosses the target. The bench sweeps the crossing cycle across eight consecutive offsets from the first fetch, and it also covers targets that are already met, met exactly, and one short. Restarts are issued on both slot parities and in the middle of a half-fetched instruction, so that abandonment and realignment can be checked against the timing rules.

// File: rtl/dlist_pkg.sv
package dlist_pkg;
  localparam int DATA_W = 16;
  localparam int REG_AW = 8;
  localparam int BEAM_W = DATA_W - 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH1,
    ST_FETCH2,
    ST_MOVEWR,
    ST_WAIT
  } stateT;

  typedef struct packed {
    logic reload;
    logic loadW1;
    logic loadW2;
    logic advance;
  } dpCtlT;
endpackage

// File: rtl/dlist_ctl.sv
module dlist_ctl
  import dlist_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  slotOdd,
  input  logic  restart,
  input  logic  isWait,
  input  logic  waitMet,
  output dpCtlT ctl,
  output logic  memRd,
  output logic  regWr
);
  stateT state, nextState;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    memRd     = 1'b0;
    regWr     = 1'b0;
    if (restart) begin
      ctl.reload = 1'b1;
      nextState  = ST_FETCH1;
    end else begin
      unique case (state)
        ST_IDLE: nextState = ST_IDLE;
        ST_FETCH1: if (slotOdd) begin
          memRd       = 1'b1;
          ctl.loadW1  = 1'b1;
          ctl.advance = 1'b1;
          nextState   = ST_FETCH2;
        end
        ST_FETCH2: if (slotOdd) begin
          memRd       = 1'b1;
          ctl.loadW2  = 1'b1;
          ctl.advance = 1'b1;
          nextState   = isWait ? ST_WAIT : ST_MOVEWR;
        end
        ST_MOVEWR: begin
          regWr     = 1'b1;
          nextState = ST_FETCH1;
        end
        ST_WAIT: if (slotOdd && waitMet) begin
          memRd     = 1'b1;
          nextState = ST_FETCH1;
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  assert_read_odd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    memRd |-> slotOdd);
  assert_write_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    regWr |=> !regWr);
  assert_write_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    regWr |-> $past(memRd));
  assert_restart_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> (!memRd && !regWr));
  assert_wake_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && memRd) |-> waitMet);
endmodule

// File: rtl/dlist_dp.sv
module dlist_dp
  import dlist_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtlT             ctl,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] memRdData,
  input  logic [BEAM_W-1:0] beamPos,
  output logic [ADDR_W-1:0] memAddr,
  output logic              isWait,
  output logic              waitMet,
  output logic [REG_AW-1:0] regAddr,
  output logic [DATA_W-1:0] regData
);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(1);

  logic [ADDR_W-1:0] fetchPtr;
  logic [REG_AW:0]   word1Low;
  logic [DATA_W-1:0] word2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetchPtr <= '0;
    end else if (ctl.reload) begin
      fetchPtr <= startAddr & ALIGN_MASK;
    end else if (ctl.advance) begin
      fetchPtr <= fetchPtr + WORD_STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word1Low <= '0;
      word2    <= '0;
    end else begin
      if (ctl.loadW1) word1Low <= memRdData[REG_AW:0];
      if (ctl.loadW2) word2    <= memRdData;
    end
  end

  assign memAddr = fetchPtr;
  assign isWait  = word1Low[0];
  assign regAddr = word1Low[REG_AW:1];
  assign regData = word2;
  assign waitMet = (beamPos >= word2[DATA_W-1:1]);

  assert_advance_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.advance && !ctl.reload) |=> (memAddr == $past(memAddr) + WORD_STEP));
  assert_reload_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.reload |=> (memAddr == ($past(startAddr) & ALIGN_MASK)));
  assert_ptr_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !memAddr[0]);
endmodule

// File: rtl/dlist_engine.sv
module dlist_engine
  import dlist_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slotOdd,
  input  logic              restart,
  input  logic [ADDR_W-1:0] startAddr,
  output logic              memRd,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [15:0]       memRdData,
  input  logic [14:0]       beamPos,
  output logic              regWr,
  output logic [7:0]        regAddr,
  output logic [15:0]       regData
);
  dpCtlT ctl;
  logic  isWait;
  logic  waitMet;

  dlist_ctl ctl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .slotOdd (slotOdd),
    .restart (restart),
    .isWait  (isWait),
    .waitMet (waitMet),
    .ctl     (ctl),
    .memRd   (memRd),
    .regWr   (regWr)
  );

  dlist_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .startAddr (startAddr),
    .memRdData (memRdData),
    .beamPos   (beamPos),
    .memAddr   (memAddr),
    .isWait    (isWait),
    .waitMet   (waitMet),
    .regAddr   (regAddr),
    .regData   (regData)
  );

  assert_idle_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!memRd && !regWr));
endmodule

// File: tb/dlist_engine_tb.sv
`timescale 1ns/100ps
module dlist_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slotOdd = 1'b0;
  logic        restart = 1'b0;
  logic [15:0] startAddr = '0;
  logic        memRd;
  logic [15:0] memAddr;
  logic [15:0] memRdData;
  logic [14:0] beamPos = '0;
  logic        regWr;
  logic [7:0]  regAddr;
  logic [15:0] regData;

  logic [15:0] mem [0:127];
  assign memRdData = mem[memAddr[7:1]];

  always #2.5 clk = ~clk;

  dlist_engine #(.ADDR_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .slotOdd(slotOdd), .restart(restart),
    .startAddr(startAddr), .memRd(memRd), .memAddr(memAddr),
    .memRdData(memRdData), .beamPos(beamPos), .regWr(regWr),
    .regAddr(regAddr), .regData(regData));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int cr = 0;
  bit logOn = 1'b0;
  int nRd, nWr, evenRd;
  int rdC [0:63];
  logic [15:0] rdA [0:63];
  int wrC [0:63];
  logic [7:0] wrA [0:63];
  logic [15:0] wrD [0:63];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearLog();
    nRd = 0; nWr = 0; evenRd = 0;
  endtask

  task automatic sample();
    if (logOn) begin
      if (memRd) begin
        if (!slotOdd) evenRd++;
        if (nRd < 64) begin rdC[nRd] = cyc; rdA[nRd] = memAddr; end
        nRd++;
      end
      if (regWr) begin
        if (nWr < 64) begin wrC[nWr] = cyc; wrA[nWr] = regAddr; wrD[nWr] = regData; end
        nWr++;
      end
    end
  endtask

  task automatic step();
    #1 sample();
    @(posedge clk);
    #1;
    cyc++;
    slotOdd = ~slotOdd;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  function automatic int firstOdd(input int c);
    return (c % 2 == 1) ? c : c + 1;
  endfunction

  task automatic doRestart(input logic [15:0] addr, input int par);
    while (cyc % 2 != par) step();
    startAddr = addr;
    restart = 1'b1;
    cr = cyc;
    logOn = 1'b1;
    clearLog();
    step();
    restart = 1'b0;
    chk(nRd == 0 && nWr == 0, "R8 quiet in restart cycle", nRd + nWr, 0);
    clearLog();
  endtask

  task automatic initMoves();
    for (int i = 0; i < 64; i++) begin
      logic [6:0] junk;
      junk = (i % 2 == 1) ? 7'(i * 19 + 3) : 7'd0;
      mem[2*i]   = {junk, 8'(i * 37 + 5), 1'b0};
      mem[2*i+1] = 16'(i * 1234 + 77);
    end
  endtask

  task automatic checkMoves(input logic [15:0] s, input int n, input int f, input string tag);
    for (int i = 0; i < n; i++) begin
      logic [15:0] a;
      a = s + 16'(4 * i);
      chk(rdC[2*i] == f + 4*i && rdA[2*i] == a, {tag, " R3 R5 word1 read"}, rdA[2*i], a);
      chk(rdC[2*i+1] == f + 4*i + 2 && rdA[2*i+1] == a + 16'd2, {tag, " R3 word2 read"},
          rdC[2*i+1], f + 4*i + 2);
      chk(wrC[i] == f + 4*i + 3, {tag, " R4 R5 write cycle"}, wrC[i], f + 4*i + 3);
      chk(wrA[i] == mem[a[7:1]][8:1], {tag, " R4 R10 write address"}, wrA[i], mem[a[7:1]][8:1]);
      chk(wrD[i] == mem[7'(a[7:1] + 7'd1)], {tag, " R4 write data"}, wrD[i], mem[7'(a[7:1] + 7'd1)]);
    end
  endtask

  task automatic setupWait(input logic [14:0] tgt);
    initMoves();
    mem[32] = 16'h0001;
    mem[33] = {tgt, 1'b1};
    mem[34] = {7'd0, 8'h55, 1'b0};
    mem[35] = 16'hC3A5;
  endtask

  task automatic checkWait(input int f, input int w, input string tag);
    chk(rdC[0] == f && rdA[0] == 16'h0040, {tag, " R3 hold word1"}, rdC[0], f);
    chk(rdC[1] == f + 2 && rdA[1] == 16'h0042, {tag, " R3 hold word2"}, rdC[1], f + 2);
    chk(rdC[2] == w && rdA[2] == 16'h0044, {tag, " R6 wake read"}, rdC[2], w);
    chk(rdC[3] == w + 2 && rdA[3] == 16'h0044, {tag, " R6 next fetch"}, rdC[3], w + 2);
    chk(rdC[4] == w + 4 && rdA[4] == 16'h0046, {tag, " R6 next word2"}, rdC[4], w + 4);
    chk(nWr >= 1 && wrC[0] == w + 5 && wrA[0] == 8'h55 && wrD[0] == 16'hC3A5,
        {tag, " R6 only the following load writes"}, wrC[0], w + 5);
  endtask

  initial begin
    initMoves();
    logOn = 1'b1;
    clearLog();
    run(4);
    rst_n = 1'b1;
    run(12);
    chk(nRd == 0 && nWr == 0, "R1 quiet after reset", nRd + nWr, 0);

    // Register-load sweep: start address x restart parity, including wrap (R9)
    begin
      logic [15:0] starts [0:3];
      starts[0] = 16'h0000; starts[1] = 16'h0010;
      starts[2] = 16'h007C; starts[3] = 16'hFFF8;
      for (int si = 0; si < 4; si++) begin
        for (int par = 0; par < 2; par++) begin
          doRestart(starts[si], par);
          run(30);
          checkMoves(starts[si], 6, firstOdd(cr + 1), si == 3 ? "R9 wrap" : "R5 sweep");
          chk(evenRd == 0, "R2 odd slots only", evenRd, 0);
        end
      end
    end

    // Odd start address is aligned down (R8)
    doRestart(16'h0021, 0);
    run(12);
    chk(rdA[0] == 16'h0020, "R8 start aligned", rdA[0], 16'h0020);
    checkMoves(16'h0020, 2, firstOdd(cr + 1), "R8 aligned");

    // Beam hold: sweep crossing cycle, including a target already met (R7)
    for (int d = -1; d < 8; d++) begin
      int f, x, w;
      logic [14:0] tgt;
      tgt = 15'd100;
      setupWait(tgt);
      beamPos = (d < 0) ? tgt : 15'd0;
      doRestart(16'h0040, d % 2 == 0 ? 1 : 0);
      f = firstOdd(cr + 1);
      x = (d < 0) ? cr : f + d;
      while (cyc < x) step();
      beamPos = (d % 2 == 0) ? tgt : 15'h7FFF;
      run(24);
      w = (x > f + 4) ? firstOdd(x) : f + 4;
      checkWait(f, w, d < 0 ? "R7 met" : "R6 sweep");
      if (d < 0)
        chk(rdC[3] == f + 6, "R7 six slots", rdC[3], f + 6);
      chk(evenRd == 0, "R2 odd slots in hold", evenRd, 0);
    end

    // Boundary: one short holds, exact value releases (R6)
    begin
      int f, w;
      setupWait(15'h7FFF);
      beamPos = 15'h7FFE;
      doRestart(16'h0040, 0);
      f = firstOdd(cr + 1);
      run(40);
      chk(nRd == 2 && nWr == 0, "R6 one short keeps holding", nRd, 2);
      beamPos = 15'h7FFF;
      w = firstOdd(cyc);
      run(12);
      checkWait(f, w, "R6 exact target");
    end

    // Restart in the middle of a fetch abandons it (R8)
    begin
      int f2;
      initMoves();
      doRestart(16'h0000, 0);
      run(2);
      doRestart(16'h0100, 0);
      f2 = firstOdd(cr + 1);
      run(10);
      chk(wrA[0] == mem[0][8:1] && wrD[0] == mem[1], "R8 abandon half fetch", wrD[0], mem[1]);
      chk(rdC[0] == f2 && rdA[0] == 16'h0100, "R8 new list first read", rdC[0], f2);
    end

    // Restart during a hold abandons it (R8)
    begin
      int f2;
      setupWait(15'd500);
      beamPos = 15'd0;
      doRestart(16'h0040, 1);
      run(12);
      doRestart(16'h0008, 1);
      f2 = firstOdd(cr + 1);
      run(10);
      chk(rdC[0] == f2 && rdA[0] == 16'h0008, "R8 leave hold", rdA[0], 16'h0008);
      chk(wrA[0] == mem[4][8:1] && wrD[0] == mem[5], "R8 R10 load after hold", wrA[0], mem[4][8:1]);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule